// File: doc/BRIEF.md
# Complementary Three-Phase PWM Generator

This block drives a three-phase motor bridge. Each of the three phases has a high-side and a low-side output, so there are six outputs in all. One carrier counter is shared by all phases. It runs either as a sawtooth that counts up and wraps, or as a triangle that counts up to the period and back down to zero. Each phase compares the carrier with its own duty value. Dead-time logic keeps the two outputs of a pair apart whenever they switch over.

Software writes the period and the three duties into shadow registers. The running waveform only takes the new values at the carrier boundary, so a write never corrupts a cycle in progress. An external fault input shuts all outputs off at once and latches. The block also gives a pulse at the top and at the bottom of the carrier, and a converter start pulse locked to one of them.

Top module: `tri_phase_pwm`

## Requirements
- R1: After reset every output is low, and the fault latch is clear.
- R2: In sawtooth mode (tri_mode=0) with active period P>0, the carrier counts 0..P and wraps. ovf_evt pulses for one cycle every P+1 cycles, and unf_evt never pulses.
- R3: In triangle mode (tri_mode=1), the carrier counts up to P and back down to 0, giving a cycle of 2P clocks. ovf_evt pulses when the carrier is at P. unf_evt pulses when it is back at 0 on the way down, P clocks after ovf_evt. The two pulses never occur together.
- R4: Phase k (duty bits [8k+7:8k] with the default width) has a raw drive that is on while the carrier is below its duty. A duty of 0 keeps the high output off. A duty above P keeps it permanently on.
- R5: Each output follows a change of its phase's raw drive after one clock. A turn-on edge waits a further dead_cyc clocks, while a turn-off edge does not wait. The high and low outputs of a pair are never both high.
- R6: A raw pulse lasting L clocks gives an output pulse of L-dead_cyc clocks when L>dead_cyc. It gives no pulse at all when L<=dead_cyc.
- R7: buf_wr captures period_in and duty_in into shadow registers. While running, the shadow values become active only at the boundary: the wrap in sawtooth mode, or the cycle where unf_evt is high in triangle mode. While stopped, they become active one clock after the write.
- R8: A buf_wr that falls in the same cycle as a boundary is applied at the following boundary. That boundary still loads the values written before it.
- R9: While fault_in is high, or while the fault latch is set, all six outputs are low, in the same cycle that fault_in rises.
- R10: The fault latch sets one clock after fault_in is high. It clears one clock after fault_clr is high while fault_in is low. If both fault_in and fault_clr are high, the set wins.
- R11: adc_trig equals ovf_evt when adc_peak=1 or when in sawtooth mode. Otherwise it equals unf_evt.
- R12: While run is low, the carrier is held at 0, no event pulses occur, and all six outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Carrier enable; low stops and idles the unit |
| tri_mode | input | 1 | 1 selects triangle carrier, 0 sawtooth (change only while stopped) |
| adc_peak | input | 1 | Triangle mode: 1 triggers the converter at the peak, 0 at the valley |
| period_in | input | CW | Period value for the shadow register |
| duty_in | input | PH*CW | Three duty values, phase k in bits [k*CW +: CW] |
| buf_wr | input | 1 | Write strobe for the shadow registers |
| dead_cyc | input | DW | Dead time in clocks |
| fault_in | input | 1 | External fault, active high |
| fault_clr | input | 1 | Clears the fault latch when fault_in is low |
| pwm_hi | output | PH | High-side outputs |
| pwm_lo | output | PH | Low-side outputs |
| ovf_evt | output | 1 | Carrier-at-peak (sawtooth: wrap) pulse |
| unf_evt | output | 1 | Triangle carrier-at-valley pulse |
| adc_trig | output | 1 | Converter start pulse |
| fault_active | output | 1 | Fault latch state |

## Verification
A shadow write can land in the very cycle in which the carrier reaches its boundary. In that case the load must take the older shadow contents while the new write goes into the shadow. The bench provokes this on purpose by waiting for the valley pulse and strobing buf_wr in that cycle. It then counts high-side clocks over the next two carrier cycles: three clocks under the old duty, then six under the new one. The same collision also happens by accident throughout a sweep over both modes, periods 1 to 5, every duty, and dead times 0 to 3. That sweep includes mid-run writes and fault pulses, and a cycle-level model computed from the requirements judges every clock.

// File: rtl/tri_phase_pwm.sv
module tri_phase_pwm #(
  parameter int CW = 8,
  parameter int DW = 4,
  parameter int PH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tri_mode,
  input  logic             adc_peak,
  input  logic [CW-1:0]    period_in,
  input  logic [PH*CW-1:0] duty_in,
  input  logic             buf_wr,
  input  logic [DW-1:0]    dead_cyc,
  input  logic             fault_in,
  input  logic             fault_clr,
  output logic [PH-1:0]    pwm_hi,
  output logic [PH-1:0]    pwm_lo,
  output logic             ovf_evt,
  output logic             unf_evt,
  output logic             adc_trig,
  output logic             fault_active
);

  logic [CW-1:0]    cnt, per_buf, per_act;
  logic [PH*CW-1:0] duty_buf, duty_act;
  logic             cnt_down;
  logic             at_top, at_bot, boundary, out_en;

  assign at_top   = run && (per_act != '0) && (cnt == per_act);
  assign at_bot   = run && tri_mode && (per_act != '0) && (cnt == '0) && cnt_down;
  assign boundary = tri_mode ? at_bot : at_top;
  assign ovf_evt  = at_top;
  assign unf_evt  = at_bot;
  assign adc_trig = (adc_peak || !tri_mode) ? at_top : at_bot;
  assign out_en   = run && !fault_in && !fault_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_buf  <= '0;
      duty_buf <= '0;
    end else if (buf_wr) begin
      per_buf  <= period_in;
      duty_buf <= duty_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_act  <= '0;
      duty_act <= '0;
    end else if (!run || boundary) begin
      per_act  <= per_buf;
      duty_act <= duty_buf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run || per_act == '0) begin
      cnt      <= '0;
      cnt_down <= 1'b0;
    end else if (!tri_mode) begin
      cnt_down <= 1'b0;
      cnt      <= (cnt == per_act) ? '0 : cnt + CW'(1);
    end else if (!cnt_down) begin
      if (cnt == per_act) begin
        cnt_down <= 1'b1;
        cnt      <= cnt - CW'(1);
      end else begin
        cnt <= cnt + CW'(1);
      end
    end else begin
      if (cnt == '0) begin
        cnt_down <= 1'b0;
        cnt      <= cnt + CW'(1);
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         fault_active <= 1'b0;
    else if (fault_in)  fault_active <= 1'b1;
    else if (fault_clr) fault_active <= 1'b0;
  end

  for (genvar g = 0; g < PH; g++) begin : g_phase
    logic          raw, rq;
    logic [DW-1:0] dtc;
    logic          settled;

    assign raw     = cnt < duty_act[g*CW +: CW];
    assign settled = dtc >= dead_cyc;

    always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
        rq  <= 1'b0;
        dtc <= '0;
      end else if (raw != rq) begin
        rq  <= raw;
        dtc <= '0;
      end else if (dtc < dead_cyc) begin
        dtc <= dtc + DW'(1);
      end
    end

    assign pwm_hi[g] = out_en && rq && settled;
    assign pwm_lo[g] = out_en && !rq && settled;
  end

endmodule

// File: rtl/tri_phase_pwm_chk.sv
module tri_phase_pwm_chk #(
  parameter int CW = 8,
  parameter int DW = 4,
  parameter int PH = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          tri_mode,
  input logic [DW-1:0] dead_cyc,
  input logic          fault_in,
  input logic          fault_clr,
  input logic [PH-1:0] pwm_hi,
  input logic [PH-1:0] pwm_lo,
  input logic          ovf_evt,
  input logic          unf_evt,
  input logic          adc_trig,
  input logic          fault_active
);

  assert_pair_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_hi & pwm_lo) == '0);

  assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_in || fault_active) |-> (pwm_hi == '0 && pwm_lo == '0));

  assert_fault_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_in |=> fault_active);

  assert_fault_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_active && !fault_clr) |=> fault_active);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!ovf_evt && !unf_evt && !adc_trig && pwm_hi == '0 && pwm_lo == '0));

  assert_saw_no_unf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tri_mode |-> !unf_evt);

  assert_evt_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_evt && unf_evt));

  assert_adc_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> (ovf_evt || unf_evt));

  for (genvar i = 0; i < PH; i++) begin : g_gap
    assert_turn_on_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && dead_cyc != '0 && $stable(dead_cyc) && $rose(pwm_hi[i]))
        |-> !$past(pwm_lo[i]));
  end

endmodule

bind tri_phase_pwm tri_phase_pwm_chk #(.CW(CW), .DW(DW), .PH(PH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .tri_mode(tri_mode), .dead_cyc(dead_cyc),
  .fault_in(fault_in), .fault_clr(fault_clr), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
  .ovf_evt(ovf_evt), .unf_evt(unf_evt), .adc_trig(adc_trig), .fault_active(fault_active)
);

// File: tb/tri_phase_pwm_test.sv
`timescale 1ns/1ps
module tri_phase_pwm_test;
  localparam int CW = 8, DW = 4, PH = 3;

  logic clk = 0, rst_n = 0, run = 0, tri_mode = 0, adc_peak = 0;
  logic [CW-1:0] period_in = '0;
  logic [PH*CW-1:0] duty_in = '0;
  logic buf_wr = 0, fault_in = 0, fault_clr = 0;
  logic [DW-1:0] dead_cyc = '0;
  logic [PH-1:0] pwm_hi, pwm_lo;
  logic ovf_evt, unf_evt, adc_trig, fault_active;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  tri_phase_pwm #(.CW(CW), .DW(DW), .PH(PH)) uut (.*);

  // cycle model derived from the requirements
  logic [CW-1:0] m_cnt, m_pb, m_pa;
  logic m_down, m_flt;
  logic [CW-1:0] m_db [PH];
  logic [CW-1:0] m_da [PH];
  logic m_rq [PH];
  int   m_dtc [PH];

  function automatic logic m_top();
    return run && m_pa != 0 && m_cnt == m_pa;
  endfunction
  function automatic logic m_bot();
    return run && tri_mode && m_pa != 0 && m_cnt == 0 && m_down;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_pb <= 0; m_pa <= 0; m_down <= 0; m_flt <= 0;
      for (int i = 0; i < PH; i++) begin
        m_db[i] <= 0; m_da[i] <= 0; m_rq[i] <= 0; m_dtc[i] <= 0;
      end
    end else begin
      for (int i = 0; i < PH; i++) begin
        if (!run) begin m_rq[i] <= 0; m_dtc[i] <= 0; end
        else if ((m_cnt < m_da[i]) != m_rq[i]) begin m_rq[i] <= (m_cnt < m_da[i]); m_dtc[i] <= 0; end
        else if (m_dtc[i] < int'(dead_cyc)) m_dtc[i] <= m_dtc[i] + 1;
        if (buf_wr) m_db[i] <= duty_in[i*CW +: CW];
        if (!run || (tri_mode ? m_bot() : m_top())) m_da[i] <= m_db[i];
      end
      if (buf_wr) m_pb <= period_in;
      if (!run || (tri_mode ? m_bot() : m_top())) m_pa <= m_pb;
      if (!run || m_pa == 0) begin m_cnt <= 0; m_down <= 0; end
      else if (!tri_mode) begin m_down <= 0; m_cnt <= (m_cnt == m_pa) ? 0 : m_cnt + 1; end
      else if (!m_down) begin
        if (m_cnt == m_pa) begin m_down <= 1; m_cnt <= m_cnt - 1; end else m_cnt <= m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin m_down <= 0; m_cnt <= m_cnt + 1; end else m_cnt <= m_cnt - 1;
      end
      if (fault_in) m_flt <= 1; else if (fault_clr) m_flt <= 0;
    end
  end

  function automatic int m_expect();
    logic [PH-1:0] h, l;
    logic en;
    en = run && !fault_in && !m_flt;
    for (int i = 0; i < PH; i++) begin
      h[i] = en && m_rq[i] && m_dtc[i] >= int'(dead_cyc);
      l[i] = en && !m_rq[i] && m_dtc[i] >= int'(dead_cyc);
    end
    return int'({h, l, m_top(), m_bot(),
                 (adc_peak || !tri_mode) ? m_top() : m_bot(), m_flt});
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    int a, e;
    @(posedge clk); #1;
    a = int'({pwm_hi, pwm_lo, ovf_evt, unf_evt, adc_trig, fault_active});
    e = m_expect();
    chk(a == e, "R2 R3 R4 R5 R6 R7 R8 model", a, e);
  endtask

  task automatic setup(input bit tm, input int p, input int d, input int dt);
    run = 0; tri_mode = tm; dead_cyc = DW'(dt); period_in = CW'(p);
    duty_in = {CW'(d), CW'(d), CW'(d)}; buf_wr = 1; step(); buf_wr = 0; step(); step();
    run = 1;
  endtask

  initial begin
    #900000;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int last, cnt_a, cnt_b, bad, lo, lu;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk({pwm_hi, pwm_lo, ovf_evt, unf_evt, adc_trig, fault_active} == '0, "R1 reset",
        int'({pwm_hi, pwm_lo, fault_active}), 0);

    // R2 sawtooth spacing
    setup(0, 4, 2, 0);
    last = -1; bad = 0; cnt_a = 0; cnt_b = 0;
    for (int c = 0; c < 22; c++) begin
      step();
      if (unf_evt) cnt_b++;
      if (ovf_evt) begin cnt_a++; if (last >= 0 && c - last != 5) bad++; last = c; end
    end
    chk(bad == 0 && cnt_a >= 4, "R2 wrap spacing", bad, 0);
    chk(cnt_b == 0, "R2 no valley pulse", cnt_b, 0);

    // R3 triangle spacing, R11 trigger choice
    setup(1, 4, 2, 0);
    lo = -1; lu = -1; bad = 0; cnt_a = 0;
    for (int c = 0; c < 40; c++) begin
      adc_peak = (c >= 20);
      step();
      if (adc_trig != (adc_peak ? ovf_evt : unf_evt)) cnt_a++;
      if (ovf_evt) begin if (lo >= 0 && c - lo != 8) bad++; lo = c; end
      if (unf_evt) begin if (lo < 0 || c - lo != 4) bad++; if (lu >= 0 && c - lu != 8) bad++; lu = c; end
    end
    chk(bad == 0 && lu >= 0, "R3 peak/valley spacing", bad, 0);
    chk(cnt_a == 0, "R11 trigger in triangle", cnt_a, 0);
    setup(0, 3, 1, 0);
    cnt_a = 0;
    for (int c = 0; c < 16; c++) begin
      adc_peak = c[0]; step(); if (adc_trig != ovf_evt) cnt_a++;
    end
    chk(cnt_a == 0, "R11 trigger in sawtooth", cnt_a, 0);

    // R4 duty extremes
    setup(0, 4, 0, 0); repeat (3) step();
    cnt_a = 0; cnt_b = 0;
    for (int c = 0; c < 15; c++) begin step(); if (pwm_hi[0]) cnt_a++; if (pwm_lo[0]) cnt_b++; end
    chk(cnt_a == 0 && cnt_b == 15, "R4 duty zero", cnt_a, 0);
    setup(0, 4, 5, 0); repeat (3) step();
    cnt_a = 0;
    for (int c = 0; c < 15; c++) begin step(); if (pwm_hi[1]) cnt_a++; end
    chk(cnt_a == 15, "R4 duty above period", cnt_a, 15);

    // R6 short pulse suppression
    setup(0, 9, 3, 3); repeat (4) step();
    cnt_a = 0;
    for (int c = 0; c < 30; c++) begin step(); if (pwm_hi[2]) cnt_a++; end
    chk(cnt_a == 0, "R6 pulse equal to dead time", cnt_a, 0);
    setup(0, 9, 3, 1); repeat (4) step();
    cnt_a = 0;
    for (int c = 0; c < 20; c++) begin step(); if (pwm_hi[2]) cnt_a++; end
    chk(cnt_a == 4, "R6 pulse minus dead time", cnt_a, 4);

    // R8 write colliding with the valley
    setup(1, 3, 2, 0);
    for (int c = 0; c < 20 && !unf_evt; c++) step();
    duty_in = {CW'(4), CW'(4), CW'(4)}; buf_wr = 1;
    step(); buf_wr = 0;
    cnt_a = pwm_hi[0] ? 1 : 0;
    for (int c = 0; c < 5; c++) begin step(); if (pwm_hi[0]) cnt_a++; end
    cnt_b = 0;
    for (int c = 0; c < 6; c++) begin step(); if (pwm_hi[0]) cnt_b++; end
    chk(cnt_a == 3, "R8 old duty kept for one cycle", cnt_a, 3);
    chk(cnt_b == 6, "R7 new duty at next valley", cnt_b, 6);

    // R9 / R10 fault
    setup(1, 3, 2, 0); repeat (4) step();
    fault_in = 1; #1;
    chk(pwm_hi == 0 && pwm_lo == 0, "R9 immediate shutdown", int'({pwm_hi, pwm_lo}), 0);
    step(); fault_in = 0; fault_clr = 0;
    chk(fault_active == 1, "R10 latch set", fault_active, 1);
    step(); step();
    chk(pwm_hi == 0 && pwm_lo == 0, "R9 latched shutdown", int'({pwm_hi, pwm_lo}), 0);
    fault_in = 1; fault_clr = 1; step(); fault_in = 0; fault_clr = 0; step();
    chk(fault_active == 1, "R10 set wins over clear", fault_active, 1);
    fault_clr = 1; step(); fault_clr = 0; step(); step();
    chk(fault_active == 0 && (pwm_hi | pwm_lo) != 0, "R10 cleared and running",
        int'(fault_active), 0);

    // R12 idle
    run = 0; bad = 0;
    for (int c = 0; c < 6; c++) begin
      step(); if (ovf_evt || unf_evt || adc_trig || pwm_hi != 0 || pwm_lo != 0) bad++;
    end
    chk(bad == 0, "R12 stopped is quiet", bad, 0);

    // sweep
    for (int m = 0; m < 2; m++)
      for (int p = 1; p <= 5; p++)
        for (int d = 0; d <= p + 1; d++)
          for (int dt = 0; dt < 4; dt++) begin
            run = 0; tri_mode = m[0]; dead_cyc = DW'(dt); period_in = CW'(p);
            duty_in = {CW'(d / 2), CW'(p + 1 - d), CW'(d)}; buf_wr = 1; step();
            buf_wr = 0; step(); step();
            run = 1; adc_peak = dt[0];
            for (int c = 0; c < 6 * p + 8; c++) begin
              buf_wr = (c == p + 2);
              if (buf_wr) begin
                period_in = CW'((p % 5) + 1);
                duty_in = {CW'(d), CW'((d + 1) % (p + 2)), CW'(p - d / 2)};
              end
              fault_in = (dt == 3) && (c == 5 || c == 6);
              fault_clr = (dt == 3) && (c == 10);
              step();
            end
            run = 0; buf_wr = 0; fault_in = 0; fault_clr = 0; step();
          end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule